// File: doc/BRIEF.md
# Load/Store Operation Sequencer

This block is the control and capture logic for one execution slot that handles integer adds, loads and stores. It accepts one operation at a time. It then walks that operation through a chain of phases. In each phase it raises one request line towards a central scheduler and waits for the matching grant before it moves on.

The chain depends on the operation kind. An add needs an operand read and then a result write. A load needs an operand read, an address phase and a result write. A store needs an operand read, an address phase and a store phase. Along the way the unit latches the opcode, the immediate offset, both source operands, the effective address and the result. The latched values are presented to the rest of the pipeline.

The second source operand is kept in its own register so that a store can use it as its data. A grant counts only in the phase whose request is raised. Stray grants and surplus issues therefore cannot push the chain into a state it does not define.

Top module: `ldst_seq`

## Requirements
- R1: After reset, busy_o and all four request outputs are 0, and op_o, addr_o, result_o and st_data_o read 0.
- R2: An issue taken while idle, with operation code 0 (add), 1 (load) or 2 (store), sets busy_o and rd_req_o from the next cycle. The operation code is latched on op_o and the immediate offset is held for address forming.
- R3: For an add, a read grant captures src1_i and src2_i and moves the unit to the write phase (wr_req_o). result_o becomes src1 + src2, modulo 2^W.
- R4: For a load, a read grant moves the unit to the address phase (adr_req_o). The address grant sets addr_o to src1 + imm modulo 2^W, sets result_o to ld_data_i and moves the unit to the write phase.
- R5: For a store, the address grant sets addr_o to src1 + imm and moves the unit to the store phase (st_req_o). st_data_o presents the captured second operand, src2_i.
- R6: At most one request output is high in any cycle, and busy_o is high exactly when one of them is.
- R7: A grant whose request line is low is ignored. The phase and every captured value are unchanged.
- R8: An issue that arrives while busy_o is high is ignored, even in the cycle of the closing write or store grant. The latched opcode and immediate are left unchanged.
- R9: An issue with operation code 3 is ignored and the unit stays idle.
- R10: A write or store grant ends the operation. busy_o is 0 in the next cycle, and an issue in that cycle is accepted.
- R11: A request stays raised for as many cycles as its grant is withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Issue strobe for a new operation |
| op_i | input | 2 | Operation code: 0 add, 1 load, 2 store, 3 rejected |
| imm_i | input | W | Immediate address offset, latched at issue |
| src1_i | input | W | First source operand, latched at read grant |
| src2_i | input | W | Second source operand, latched at read grant |
| ld_data_i | input | W | Load return data, latched at address grant for loads |
| rd_req_o | output | 1 | Operand read request |
| rd_gnt_i | input | 1 | Operand read grant |
| adr_req_o | output | 1 | Address phase request |
| adr_gnt_i | input | 1 | Address phase grant |
| wr_req_o | output | 1 | Result write request |
| wr_gnt_i | input | 1 | Result write grant |
| st_req_o | output | 1 | Store request |
| st_gnt_i | input | 1 | Store grant |
| busy_o | output | 1 | Unit occupied |
| op_o | output | 2 | Latched operation code |
| addr_o | output | W | Captured effective address |
| result_o | output | W | Captured result (add sum or load data) |
| st_data_o | output | W | Captured second operand, used as store data |

## Verification
Two functions can land on the same clock edge: the closing grant of one operation and the issue of the next. The bench raises issue_i in the same cycle as a final write grant, with a different opcode and immediate. It then checks that busy_o is low afterwards and that a later run still forms its address from the original immediate. The bench also lays stray grants for other phases, with altered operands, on top of a phase that is still waiting. It judges these by the request line held and by the captured values the operation finally presents.

// File: rtl/ldst_seq_pkg.sv
package ldst_seq_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_LD  = 2'd1,
    OP_ST  = 2'd2,
    OP_BAD = 2'd3
  } op_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RD   = 3'd1,
    PH_ADR  = 3'd2,
    PH_WR   = 3'd3,
    PH_ST   = 3'd4
  } phase_e;
endpackage

// File: rtl/ldst_seq_fsm.sv
module ldst_seq_fsm
  import ldst_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     issue_i,
  input  logic [1:0] op_i,
  input  op_kind_e op_q_i,
  input  logic     rd_gnt_i,
  input  logic     adr_gnt_i,
  input  logic     wr_gnt_i,
  input  logic     st_gnt_i,
  output logic     cap_issue_o,
  output logic     cap_rd_o,
  output logic     cap_adr_o,
  output phase_e   phase_o
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d        = ph_q;
    cap_issue_o = 1'b0;
    cap_rd_o    = 1'b0;
    cap_adr_o   = 1'b0;
    case (ph_q)
      PH_IDLE: if (issue_i && (op_i != OP_BAD)) begin
        ph_d        = PH_RD;
        cap_issue_o = 1'b1;
      end
      PH_RD: if (rd_gnt_i) begin
        cap_rd_o = 1'b1;
        ph_d     = (op_q_i == OP_ADD) ? PH_WR : PH_ADR;
      end
      PH_ADR: if (adr_gnt_i) begin
        cap_adr_o = 1'b1;
        ph_d      = (op_q_i == OP_LD) ? PH_WR : PH_ST;
      end
      PH_WR:   if (wr_gnt_i) ph_d = PH_IDLE;
      PH_ST:   if (st_gnt_i) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_IDLE;
    else         ph_q <= ph_d;
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/ldst_seq_dp.sv
module ldst_seq_dp
  import ldst_seq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_issue_i,
  input  logic         cap_rd_i,
  input  logic         cap_adr_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] imm_i,
  input  logic [W-1:0] src1_i,
  input  logic [W-1:0] src2_i,
  input  logic [W-1:0] ld_data_i,
  output op_kind_e     op_q_o,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] result_o,
  output logic [W-1:0] st_data_o
);
  op_kind_e     op_q;
  logic [W-1:0] imm_q, s1_q, s2_q, addr_q, res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_ADD;
      imm_q  <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      addr_q <= '0;
      res_q  <= '0;
    end else begin
      if (cap_issue_i) begin
        op_q  <= op_kind_e'(op_i);
        imm_q <= imm_i;
      end
      if (cap_rd_i) begin
        s1_q <= src1_i;
        s2_q <= src2_i;
        if (op_q == OP_ADD) res_q <= src1_i + src2_i;
      end
      if (cap_adr_i) begin
        addr_q <= s1_q + imm_q;
        if (op_q == OP_LD) res_q <= ld_data_i;
      end
    end
  end

  assign op_q_o    = op_q;
  assign addr_o    = addr_q;
  assign result_o  = res_q;
  assign st_data_o = s2_q;
endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
  import ldst_seq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         issue_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] imm_i,
  input  logic [W-1:0] src1_i,
  input  logic [W-1:0] src2_i,
  input  logic [W-1:0] ld_data_i,
  output logic         rd_req_o,
  input  logic         rd_gnt_i,
  output logic         adr_req_o,
  input  logic         adr_gnt_i,
  output logic         wr_req_o,
  input  logic         wr_gnt_i,
  output logic         st_req_o,
  input  logic         st_gnt_i,
  output logic         busy_o,
  output logic [1:0]   op_o,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] result_o,
  output logic [W-1:0] st_data_o
);
  op_kind_e op_q;
  phase_e   phase;
  logic     cap_issue, cap_rd, cap_adr;

  ldst_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue_i),
    .op_i        (op_i),
    .op_q_i      (op_q),
    .rd_gnt_i    (rd_gnt_i),
    .adr_gnt_i   (adr_gnt_i),
    .wr_gnt_i    (wr_gnt_i),
    .st_gnt_i    (st_gnt_i),
    .cap_issue_o (cap_issue),
    .cap_rd_o    (cap_rd),
    .cap_adr_o   (cap_adr),
    .phase_o     (phase)
  );

  ldst_seq_dp #(.W(W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_issue_i (cap_issue),
    .cap_rd_i    (cap_rd),
    .cap_adr_i   (cap_adr),
    .op_i        (op_i),
    .imm_i       (imm_i),
    .src1_i      (src1_i),
    .src2_i      (src2_i),
    .ld_data_i   (ld_data_i),
    .op_q_o      (op_q),
    .addr_o      (addr_o),
    .result_o    (result_o),
    .st_data_o   (st_data_o)
  );

  assign rd_req_o  = (phase == PH_RD);
  assign adr_req_o = (phase == PH_ADR);
  assign wr_req_o  = (phase == PH_WR);
  assign st_req_o  = (phase == PH_ST);
  assign busy_o    = (phase != PH_IDLE);
  assign op_o      = op_q;
endmodule

// File: rtl/ldst_seq_chk.sv
module ldst_seq_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         issue_i,
  input logic [1:0]   op_i,
  input logic         rd_req_o,
  input logic         rd_gnt_i,
  input logic         adr_req_o,
  input logic         adr_gnt_i,
  input logic         wr_req_o,
  input logic         wr_gnt_i,
  input logic         st_req_o,
  input logic         st_gnt_i,
  input logic         busy_o,
  input logic [1:0]   op_o,
  input logic [W-1:0] addr_o
);
  logic [3:0] reqs;
  assign reqs = {rd_req_o, adr_req_o, wr_req_o, st_req_o};

  AST_REQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reqs)); // R6
  AST_BUSY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (reqs != 4'b0)); // R6
  AST_ISSUE_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && issue_i && (op_i != 2'd3) |=> rd_req_o && (op_o == $past(op_i))); // R2
  AST_BAD_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && issue_i && (op_i == 2'd3) |=> !busy_o); // R9
  AST_BUSY_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && issue_i |=> $stable(op_o)); // R8
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_gnt_i |=> rd_req_o); // R11
  AST_ADR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adr_req_o && !adr_gnt_i |=> adr_req_o); // R11
  AST_RD_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_gnt_i |=> (adr_req_o || wr_req_o)); // R3
  AST_ADR_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adr_req_o && adr_gnt_i |=> (wr_req_o || st_req_o)); // R4
  AST_STRAY_ADR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adr_gnt_i && !adr_req_o |=> $stable(addr_o)); // R7
  AST_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_gnt_i) || (st_req_o && st_gnt_i) |=> !busy_o); // R10
endmodule

bind ldst_seq ldst_seq_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .issue_i   (issue_i),
  .op_i      (op_i),
  .rd_req_o  (rd_req_o),
  .rd_gnt_i  (rd_gnt_i),
  .adr_req_o (adr_req_o),
  .adr_gnt_i (adr_gnt_i),
  .wr_req_o  (wr_req_o),
  .wr_gnt_i  (wr_gnt_i),
  .st_req_o  (st_req_o),
  .st_gnt_i  (st_gnt_i),
  .busy_o    (busy_o),
  .op_o      (op_o),
  .addr_o    (addr_o)
);

// File: tb/ldst_seq_bench.sv
module ldst_seq_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic issue_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic [W-1:0] imm_i = '0, src1_i = '0, src2_i = '0, ld_data_i = '0;
  logic rd_gnt_i = 1'b0, adr_gnt_i = 1'b0, wr_gnt_i = 1'b0, st_gnt_i = 1'b0;
  logic rd_req_o, adr_req_o, wr_req_o, st_req_o, busy_o;
  logic [1:0] op_o;
  logic [W-1:0] addr_o, result_o, st_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ldst_seq #(.W(W)) u_ldst_seq (
    .clk_i(clk), .rst_ni(rst_ni), .issue_i(issue_i), .op_i(op_i),
    .imm_i(imm_i), .src1_i(src1_i), .src2_i(src2_i), .ld_data_i(ld_data_i),
    .rd_req_o(rd_req_o), .rd_gnt_i(rd_gnt_i),
    .adr_req_o(adr_req_o), .adr_gnt_i(adr_gnt_i),
    .wr_req_o(wr_req_o), .wr_gnt_i(wr_gnt_i),
    .st_req_o(st_req_o), .st_gnt_i(st_gnt_i),
    .busy_o(busy_o), .op_o(op_o), .addr_o(addr_o),
    .result_o(result_o), .st_data_o(st_data_o)
  );

  // op(2) dly(4) src1 src2 imm ld_data exp_addr exp_value(result or store data)
  localparam logic [101:0] VEC [6] = '{
    {2'd0, 4'd0, 16'h1234, 16'h0101, 16'h0000, 16'h0000, 16'h0000, 16'h1335},
    {2'd1, 4'd2, 16'h1000, 16'h0000, 16'h0010, 16'hBEEF, 16'h1010, 16'hBEEF},
    {2'd2, 4'd1, 16'h2000, 16'hCAFE, 16'h0004, 16'h0000, 16'h2004, 16'hCAFE},
    {2'd0, 4'd3, 16'hFFFF, 16'h0002, 16'h0000, 16'h0000, 16'h0000, 16'h0001},
    {2'd1, 4'd0, 16'hFFF0, 16'h0000, 16'h0020, 16'h5A5A, 16'h0010, 16'h5A5A},
    {2'd2, 4'd2, 16'h0100, 16'h0F0F, 16'hFFFF, 16'h0000, 16'h00FF, 16'h0F0F}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  function automatic logic req_of(input int k);
    case (k)
      0: return rd_req_o;
      1: return adr_req_o;
      2: return wr_req_o;
      default: return st_req_o;
    endcase
  endfunction

  task automatic set_gnt(input int k, input logic v);
    case (k)
      0: rd_gnt_i = v;
      1: adr_gnt_i = v;
      2: wr_gnt_i = v;
      default: st_gnt_i = v;
    endcase
  endtask

  // called at a negedge; returns at a negedge after the grant edge
  task automatic grant(input int k, input int dly);
    for (int i = 0; i < dly; i++) begin
      @(posedge clk); @(negedge clk);
      check("R11 request held", W'(req_of(k)), W'(1));
      check("R6 single request", W'($countones({rd_req_o, adr_req_o, wr_req_o, st_req_o})), W'(1));
    end
    set_gnt(k, 1'b1);
    @(posedge clk); @(negedge clk);
    set_gnt(k, 1'b0);
  endtask

  task automatic issue(input logic [1:0] op, input logic [W-1:0] imm);
    issue_i = 1'b1; op_i = op; imm_i = imm;
    @(posedge clk); @(negedge clk);
    issue_i = 1'b0;
  endtask

  task automatic run_vec(input logic [101:0] v);
    logic [1:0] op;
    op = v[101:100];
    issue(op, v[63:48]);
    check("R2 busy", W'(busy_o), W'(1));
    check("R2 read request", W'(rd_req_o), W'(1));
    check("R2 opcode", W'(op_o), W'(op));
    src1_i = v[95:80]; src2_i = v[79:64];
    grant(0, int'(v[99:96]));
    src1_i = '0; src2_i = '0;
    if (op == 2'd0) begin
      check("R3 write request", W'(wr_req_o), W'(1));
      check("R3 sum", result_o, v[15:0]);
      grant(2, int'(v[99:96]));
    end else begin
      check("R4 address request", W'(adr_req_o), W'(1));
      ld_data_i = v[47:32];
      grant(1, int'(v[99:96]));
      ld_data_i = '0;
      check("R4 R5 address", addr_o, v[31:16]);
      if (op == 2'd1) begin
        check("R4 write request", W'(wr_req_o), W'(1));
        check("R4 load result", result_o, v[15:0]);
        grant(2, int'(v[99:96]));
      end else begin
        check("R5 store request", W'(st_req_o), W'(1));
        check("R5 store data", st_data_o, v[15:0]);
        grant(3, int'(v[99:96]));
      end
    end
    check("R10 idle after final grant", W'(busy_o), W'(0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 busy", W'(busy_o), W'(0));
    check("R1 requests", W'({rd_req_o, adr_req_o, wr_req_o, st_req_o}), W'(0));
    check("R1 addr", addr_o, '0);
    check("R1 result", result_o, '0);
    check("R1 store data", st_data_o, '0);
    check("R1 opcode", W'(op_o), W'(0));
    rst_ni = 1'b1;
    @(negedge clk);

    // R9: rejected code
    issue(2'd3, 16'h0055);
    check("R9 stays idle", W'(busy_o), W'(0));
    check("R9 opcode kept", W'(op_o), W'(0));

    // table walk, back-to-back issues (R10)
    for (int n = 0; n < 6; n++) run_vec(VEC[n]);

    // R7/R8: stray grants and busy issue during a load
    issue(2'd1, 16'h0010);
    issue(2'd2, 16'h0099);              // R8 ignored
    check("R8 opcode kept", W'(op_o), W'(1));
    check("R8 still reading", W'(rd_req_o), W'(1));
    adr_gnt_i = 1'b1; wr_gnt_i = 1'b1; st_gnt_i = 1'b1;
    @(posedge clk); @(negedge clk);
    adr_gnt_i = 1'b0; wr_gnt_i = 1'b0; st_gnt_i = 1'b0;
    check("R7 stray grants in read phase", W'(rd_req_o), W'(1));
    src1_i = 16'h0300;
    grant(0, 0);
    src1_i = 16'h7777; src2_i = 16'h7777;
    rd_gnt_i = 1'b1; wr_gnt_i = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_gnt_i = 1'b0; wr_gnt_i = 1'b0;
    check("R7 stray grants in address phase", W'(adr_req_o), W'(1));
    ld_data_i = 16'h4242;
    grant(1, 0);
    check("R7 R8 address uses original operand and imm", addr_o, 16'h0310);
    check("R7 store data untouched by stray read", st_data_o, 16'h0000);
    // R8: issue in the closing-grant cycle is dropped
    issue_i = 1'b1; op_i = 2'd2; imm_i = 16'h0077; wr_gnt_i = 1'b1;
    @(posedge clk); @(negedge clk);
    issue_i = 1'b0; wr_gnt_i = 1'b0;
    check("R8 issue at final grant dropped", W'(busy_o), W'(0));
    check("R8 opcode after final grant", W'(op_o), W'(1));
    // R10: new issue accepted right after
    issue(2'd2, 16'h0001);
    check("R10 new issue accepted", W'(rd_req_o), W'(1));
    src1_i = 16'h0020; src2_i = 16'h1111;
    grant(0, 0);
    grant(1, 0);
    check("R5 store address", addr_o, 16'h0021);
    check("R5 store data second operand", st_data_o, 16'h1111);
    grant(3, 0);
    check("R10 idle", W'(busy_o), W'(0));

    done = 1'b1;
    report();
    $finish;
  end
endmodule